// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block runs external transactions over one shared 32-bit bus that carries both address and data. Each transaction starts with an address phase: the full beat address goes out on the shared bus while a one-cycle latch-enable strobe is high, so an external transparent latch can hold the upper 27 bits. The five lowest address bits are never taken from that latch. They are driven on their own dedicated pins for the whole transaction and change from beat to beat. This lets narrow ports and bursts step through sub-word and beat offsets without a new address phase.

On the internal side a request carries an address, a direction, a burst flag, a port-size code and a byte count of 1 to 32. The block splits the request into beats of the port width. Write words arrive on a valid/ready stream; a word is consumed only when a beat needs one, and the bus stays quiet while `wd_valid` is low. Read words leave on a valid/ready stream; while `rd_ready` is low the word and its last flag stay frozen and no further bus beat starts. A one-cycle done pulse closes every request. A new request is taken only from idle.

Top module: `mxbus_master`

## Requirements
- R1: After reset and between transactions the block is idle. `req_ready` is high, latch-enable is low, the shared bus is undriven (`bus_ad_oe` low), both data strobes are low, and `rd_valid` and `wd_ready` are low. `req_ready` is high only in this idle state.
- R2: An address phase lasts exactly one cycle. In that cycle `bus_ale` is high, `bus_ad_oe` is high and `bus_ad_o` carries the full 32-bit address of the beat. The data phase follows in the next cycle.
- R3: `bus_alo` always carries bits [4:0] of the current beat address, including during every data strobe. A device forms its address from the latched bits [31:5] together with these pins.
- R4: Port code 0 selects an 8-bit port, 1 a 16-bit port, and 2 or 3 a 32-bit port. A request of N bytes takes N divided by the port width beats. The start address must be aligned to the port width and N must be a multiple of it. Beat data uses the most significant bits of the shared bus: [31:24] for 8-bit and [31:16] for 16-bit. A 16-bit device ignores `bus_alo[0]` and a 32-bit device ignores `bus_alo[1:0]`.
- R5: Transaction byte k is carried in stream word k/4, lane k mod 4, where lane 0 is bits [31:24]. Lanes after the final byte of the last read word read as zero.
- R6: With the burst flag set, a request has exactly one address phase. Byte k then sits at the 32-byte-aligned block of the start address, offset (start[4:0] + k) mod 32, so the beats wrap within that block.
- R7: With the burst flag clear, every beat has its own address phase, and byte k sits at start + k with no wrap.
- R8: A write beat that needs a new word (byte index a multiple of 4) waits with `wd_ready` high until `wd_valid`. While it waits there is no strobe and the bus is undriven.
- R9: A read word is offered with `rd_valid`. While `rd_ready` is low, `rd_data` and `rd_last` hold steady. `rd_last` marks the final word of the request.
- R10: `xfer_done` is a single-cycle pulse issued once per request, in the first idle cycle after the final beat (or after the final read word is taken).
- R11: A write data phase drives the bus and pulses `bus_wstb` for one cycle. A read data phase leaves the bus undriven, pulses `bus_rstb`, and samples `bus_ad_i` at the end of that cycle. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken (idle only) |
| req_addr | input | 32 | Start byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = single address phase, wrapping burst |
| req_port | input | 2 | Port size code (0: 8, 1: 16, 2/3: 32 bits) |
| req_bytes | input | 6 | Byte count, 1 to 32 |
| wd_valid | input | 1 | Write word offered |
| wd_ready | output | 1 | Write word taken |
| wd_data | input | 32 | Write word, lane 0 in [31:24] |
| rd_valid | output | 1 | Read word offered |
| rd_ready | input | 1 | Read word taken |
| rd_data | output | 32 | Read word, lane 0 in [31:24] |
| rd_last | output | 1 | Final read word of the request |
| xfer_done | output | 1 | Request complete pulse |
| bus_ad_o | output | 32 | Shared bus, value driven |
| bus_ad_oe | output | 1 | Shared bus output enable |
| bus_ad_i | input | 32 | Shared bus, value sampled |
| bus_ale | output | 1 | Address latch enable |
| bus_alo | output | 5 | Non-multiplexed low address bits |
| bus_wstb | output | 1 | Write data strobe |
| bus_rstb | output | 1 | Read data strobe |

## Verification
The bench attaches a latch-and-memory model that addresses itself only from the latched upper bits and `bus_alo`. Wrong low pins, lanes or wrapping therefore show up as wrong data in a reference-model scoreboard. Requests cover all three port widths in both burst and single-phase form. Start offsets are chosen so that a wrapping burst and a linear sequence from the same address touch different bytes, which separates R6 from R7. Partial last words check zero fill and lane order, and address-phase counts per request confirm the single-phase burst. Stalls on both streams check that `rd_data` holds and that the bus stays quiet while a write word is missing.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_ADDR,
    ST_DATA,
    ST_PUSH
  } mxb_state_e;

  localparam logic [1:0] PSZ_8  = 2'd0;
  localparam logic [1:0] PSZ_16 = 2'd1;
endpackage

// File: rtl/mxb_addr_gen.sv
module mxb_addr_gen #(
  parameter int AW   = 32,
  parameter int LOWW = 5,
  parameter int CW   = 6
) (
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] idx,
  input  logic          burst,
  output logic [AW-1:0] beat_addr
);
  logic [LOWW-1:0] wrap_lo;
  logic [AW-1:0]   linear;

  // burst beats wrap inside the aligned block, single-phase beats count up
  assign wrap_lo   = base[LOWW-1:0] + idx[LOWW-1:0];
  assign linear    = base + AW'(idx);
  assign beat_addr = burst ? {base[AW-1:LOWW], wrap_lo} : linear;
endmodule

// File: rtl/mxb_lane.sv
module mxb_lane import mxb_pkg::*; #(
  parameter int DW = 32,
  localparam int NL = DW / 8,
  localparam int LW = $clog2(NL)
) (
  input  logic [1:0]    psz,
  input  logic [LW-1:0] lane,
  input  logic [DW-1:0] wword,
  input  logic [DW-1:0] rword,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic [DW-1:0] merged
);
  // lane 0 is the most significant byte
  function automatic logic [7:0] byte_of(input logic [DW-1:0] w, input int j);
    return w[DW-1-8*j -: 8];
  endfunction

  for (genvar j = 0; j < NL; j++) begin : g_lane
    localparam logic [LW-1:0] JL = LW'(j);
    logic [7:0] ob, src;
    logic       take;

    always_comb begin
      case (psz)
        PSZ_8: begin
          ob   = (j == 0) ? byte_of(wword, int'(lane)) : 8'h00;
          take = (JL == lane);
          src  = byte_of(bus_in, 0);
        end
        PSZ_16: begin
          ob   = (j < 2) ? byte_of(wword, int'({lane[LW-1:1], 1'b0}) + j) : 8'h00;
          take = (JL[LW-1:1] == lane[LW-1:1]);
          src  = byte_of(bus_in, j % 2);
        end
        default: begin
          ob   = byte_of(wword, j);
          take = 1'b1;
          src  = byte_of(bus_in, j);
        end
      endcase
    end

    assign bus_out[DW-1-8*j -: 8] = ob;
    assign merged[DW-1-8*j -: 8]  = take ? src : byte_of(rword, j);
  end
endmodule

// File: rtl/mxb_ctrl.sv
module mxb_ctrl import mxb_pkg::*; #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_burst,
  input  logic [1:0]    req_port,
  input  logic [CW-1:0] req_bytes,
  input  logic          wd_valid,
  output logic          wd_ready,
  input  logic [DW-1:0] wd_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_last,
  output logic          xfer_done,
  input  logic [AW-1:0] beat_addr,
  input  logic [DW-1:0] lane_out,
  input  logic [DW-1:0] lane_merge,
  output logic [AW-1:0] base_q,
  output logic [CW-1:0] k_q,
  output logic          burst_q,
  output logic [1:0]    psz_q,
  output logic [DW-1:0] wbuf_q,
  output logic [DW-1:0] rbuf_q,
  output logic [DW-1:0] bus_ad_o,
  output logic          bus_ad_oe,
  output logic          bus_ale,
  output logic          bus_wstb,
  output logic          bus_rstb
);
  mxb_state_e    st;
  logic          wr_q, naddr_q, last_q, done_q;
  logic [CW-1:0] cnt_q, pb, k_next;
  logic          last_beat, word_end;

  always_comb begin
    case (psz_q)
      PSZ_8:   pb = CW'(1);
      PSZ_16:  pb = CW'(2);
      default: pb = CW'(4);
    endcase
  end

  assign k_next    = k_q + pb;
  assign last_beat = (k_next >= cnt_q);
  assign word_end  = (k_next[1:0] == 2'b00) || last_beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      base_q  <= '0;
      k_q     <= '0;
      cnt_q   <= '0;
      burst_q <= 1'b0;
      psz_q   <= '0;
      wr_q    <= 1'b0;
      naddr_q <= 1'b0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
      wbuf_q  <= '0;
      rbuf_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          base_q  <= req_addr;
          wr_q    <= req_write;
          burst_q <= req_burst;
          psz_q   <= req_port;
          cnt_q   <= req_bytes;
          k_q     <= '0;
          naddr_q <= 1'b1;
          rbuf_q  <= '0;
          st      <= req_write ? ST_FETCH : ST_ADDR;
        end
        ST_FETCH: if (wd_valid) begin
          wbuf_q <= wd_data;
          st     <= naddr_q ? ST_ADDR : ST_DATA;
        end
        ST_ADDR: st <= ST_DATA;
        ST_DATA: begin
          k_q <= k_next;
          if (!wr_q) rbuf_q <= lane_merge;
          if (!wr_q && word_end) begin
            last_q <= last_beat;
            st     <= ST_PUSH;
          end else if (last_beat) begin
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            naddr_q <= !burst_q;
            if (wr_q && k_next[1:0] == 2'b00) st <= ST_FETCH;
            else                              st <= burst_q ? ST_DATA : ST_ADDR;
          end
        end
        ST_PUSH: if (rd_ready) begin
          rbuf_q <= '0;
          if (last_q) begin
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            st <= burst_q ? ST_DATA : ST_ADDR;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign wd_ready  = (st == ST_FETCH);
  assign rd_valid  = (st == ST_PUSH);
  assign rd_data   = rbuf_q;
  assign rd_last   = last_q;
  assign xfer_done = done_q;

  assign bus_ale   = (st == ST_ADDR);
  assign bus_wstb  = (st == ST_DATA) && wr_q;
  assign bus_rstb  = (st == ST_DATA) && !wr_q;
  assign bus_ad_oe = bus_ale || bus_wstb;
  assign bus_ad_o  = bus_ale ? beat_addr[DW-1:0] : (bus_wstb ? lane_out : '0);
endmodule

// File: rtl/mxbus_master.sv
module mxbus_master #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int LOWW = 5,
  parameter int CW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_burst,
  input  logic [1:0]    req_port,
  input  logic [CW-1:0] req_bytes,
  input  logic          wd_valid,
  output logic          wd_ready,
  input  logic [DW-1:0] wd_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_last,
  output logic          xfer_done,
  output logic [DW-1:0] bus_ad_o,
  output logic          bus_ad_oe,
  input  logic [DW-1:0] bus_ad_i,
  output logic          bus_ale,
  output logic [LOWW-1:0] bus_alo,
  output logic          bus_wstb,
  output logic          bus_rstb
);
  localparam int LW = $clog2(DW / 8);

  logic [AW-1:0] base_q, beat_addr;
  logic [CW-1:0] k_q;
  logic          burst_q;
  logic [1:0]    psz_q;
  logic [DW-1:0] wbuf_q, rbuf_q, lane_out, lane_merge;

  mxb_ctrl #(.AW(AW), .DW(DW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_burst(req_burst), .req_port(req_port),
    .req_bytes(req_bytes),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last),
    .xfer_done(xfer_done),
    .beat_addr(beat_addr), .lane_out(lane_out), .lane_merge(lane_merge),
    .base_q(base_q), .k_q(k_q), .burst_q(burst_q), .psz_q(psz_q),
    .wbuf_q(wbuf_q), .rbuf_q(rbuf_q),
    .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe), .bus_ale(bus_ale),
    .bus_wstb(bus_wstb), .bus_rstb(bus_rstb)
  );

  mxb_addr_gen #(.AW(AW), .LOWW(LOWW), .CW(CW)) u_agen (
    .base(base_q), .idx(k_q), .burst(burst_q), .beat_addr(beat_addr)
  );

  mxb_lane #(.DW(DW)) u_lane (
    .psz(psz_q), .lane(k_q[LW-1:0]), .wword(wbuf_q), .rword(rbuf_q),
    .bus_in(bus_ad_i), .bus_out(lane_out), .merged(lane_merge)
  );

  assign bus_alo = beat_addr[LOWW-1:0];
endmodule

// File: rtl/mxb_checker.sv
module mxb_checker #(
  parameter int DW   = 32,
  parameter int LOWW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            wd_ready,
  input logic            rd_valid,
  input logic            rd_ready,
  input logic [DW-1:0]   rd_data,
  input logic            rd_last,
  input logic            xfer_done,
  input logic [DW-1:0]   bus_ad_o,
  input logic            bus_ad_oe,
  input logic            bus_ale,
  input logic [LOWW-1:0] bus_alo,
  input logic            bus_wstb,
  input logic            bus_rstb
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_ale && !bus_ad_oe && !bus_wstb && !bus_rstb && !rd_valid && !wd_ready);

  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> !bus_ale);

  p_ale_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> bus_ad_oe && !bus_wstb && !bus_rstb);

  p_ale_then_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> (bus_wstb || bus_rstb));

  p_low_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> (bus_ad_o[LOWW-1:0] == bus_alo));

  p_wait_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ready |-> !bus_wstb && !bus_rstb && !bus_ad_oe);

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && $stable(rd_last));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> req_ready);

  p_read_float_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rstb |-> !bus_ad_oe);

  p_write_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wstb |-> bus_ad_oe);

  p_strobe_mutex_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wstb && bus_rstb));
endmodule

bind mxbus_master mxb_checker #(.DW(DW), .LOWW(LOWW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .wd_ready(wd_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last),
  .xfer_done(xfer_done), .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe),
  .bus_ale(bus_ale), .bus_alo(bus_alo), .bus_wstb(bus_wstb), .bus_rstb(bus_rstb)
);

// File: tb/sim_mxbus_master.sv
`timescale 1ns/1ps
module sim_mxbus_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_port = '0;
  logic [5:0]  req_bytes = '0;
  logic        wd_valid = 1'b0, wd_ready;
  logic [31:0] wd_data = '0;
  logic        rd_valid, rd_ready = 1'b0, rd_last;
  logic [31:0] rd_data;
  logic        xfer_done;
  logic [31:0] bus_ad_o, bus_ad_i;
  logic        bus_ad_oe, bus_ale, bus_wstb, bus_rstb;
  logic [4:0]  bus_alo;

  always #2 clk = ~clk;

  mxbus_master u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_burst(req_burst), .req_port(req_port),
    .req_bytes(req_bytes),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last),
    .xfer_done(xfer_done),
    .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe), .bus_ad_i(bus_ad_i),
    .bus_ale(bus_ale), .bus_alo(bus_alo), .bus_wstb(bus_wstb), .bus_rstb(bus_rstb)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- external latch and memory model ----------------
  logic [7:0] mem [256];
  logic [7:0] refm [256];
  logic [2:0] lat;
  logic [1:0] cur_ps = 2'd2;
  logic [7:0] midx;
  logic [31:0] rdword;

  always_comb begin
    case (cur_ps)
      2'd0:    midx = {lat, bus_alo};
      2'd1:    midx = {lat, bus_alo[4:1], 1'b0};
      default: midx = {lat, bus_alo[4:2], 2'b00};
    endcase
    case (cur_ps)
      2'd0:    rdword = {mem[midx], 24'h0};
      2'd1:    rdword = {mem[midx], mem[8'(midx + 1)], 16'h0};
      default: rdword = {mem[midx], mem[8'(midx + 1)], mem[8'(midx + 2)], mem[8'(midx + 3)]};
    endcase
  end
  assign bus_ad_i = bus_rstb ? rdword : 32'h0;

  always @(posedge clk) begin
    if (!rst_n) begin
      lat <= '0;
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
    end else begin
      if (bus_ale) lat <= bus_ad_o[7:5];
      if (bus_wstb) begin
        mem[midx] <= bus_ad_o[31:24];
        if (cur_ps != 2'd0) mem[8'(midx + 1)] <= bus_ad_o[23:16];
        if (cur_ps[1]) begin
          mem[8'(midx + 2)] <= bus_ad_o[15:8];
          mem[8'(midx + 3)] <= bus_ad_o[7:0];
        end
      end
    end
  end

  // ---------------- scoreboard queues ----------------
  logic [31:0] exp_rq[$];
  logic        exp_lq[$];
  logic [31:0] exp_aq[$];
  logic [4:0]  exp_bq[$];
  logic [31:0] wq[$];
  int          exp_ale = 0, ale_seen = 0;
  int          seed = 17;

  function automatic logic [31:0] byte_addr(input logic [31:0] a, input int k, input bit bu);
    if (bu) return {a[31:5], 5'(a[4:0] + 5'(k))};
    return a + 32'(k);
  endfunction

  // write stream source with periodic stalls
  int fcyc = 0;
  initial forever begin
    @(negedge clk);
    fcyc++;
    wd_valid = (wq.size() > 0) && (fcyc % 3 != 2);
    wd_data  = (wq.size() > 0) ? wq[0] : 32'h0;
    #1;
    if (wd_valid && wd_ready) void'(wq.pop_front());
  end

  // monitor
  int mcyc = 0;
  initial forever begin
    @(negedge clk);
    mcyc++;
    rd_ready = (mcyc % 4 != 1);
    #1;
    if (rst_n) begin
      if (bus_ale) begin
        ale_seen++;
        if (exp_aq.size() == 0) chk(0, "R7 unexpected address phase", bus_ad_o, 32'h0);
        else begin
          logic [31:0] ea;
          ea = exp_aq.pop_front();
          chk(bus_ad_o == ea && bus_ad_oe, "R2 address phase value", bus_ad_o, ea);
        end
      end
      if (bus_wstb || bus_rstb) begin
        if (exp_bq.size() == 0) chk(0, "R4 unexpected data beat", 32'(bus_alo), 32'h0);
        else begin
          logic [4:0] eb;
          eb = exp_bq.pop_front();
          chk(bus_alo == eb, "R3 R6 low address pins on beat", 32'(bus_alo), 32'(eb));
        end
      end
      if (rd_valid && rd_ready) begin
        if (exp_rq.size() == 0) chk(0, "R9 unexpected read word", rd_data, 32'h0);
        else begin
          logic [31:0] ew;
          logic        el;
          ew = exp_rq.pop_front();
          el = exp_lq.pop_front();
          chk(rd_data == ew, "R5 read word lanes", rd_data, ew);
          chk(rd_last == el, "R9 last flag", 32'(rd_last), 32'(el));
        end
      end
      if (xfer_done) begin
        chk(ale_seen == exp_ale, "R6 R7 address phases per request", 32'(ale_seen), 32'(exp_ale));
        ale_seen = 0;
      end
    end
  end

  task automatic run(input logic [31:0] a, input bit wr, input logic [1:0] ps, input bit bu, input int n);
    int pb;
    logic [31:0] w;
    int mism;
    pb = (ps == 2'd0) ? 1 : (ps == 2'd1) ? 2 : 4;
    for (int k = 0; k < n; k += pb) begin
      logic [31:0] ba;
      ba = byte_addr(a, k, bu);
      exp_bq.push_back(ba[4:0]);
      if (!bu || k == 0) exp_aq.push_back(ba);
    end
    exp_ale = bu ? 1 : n / pb;
    w = '0;
    for (int k = 0; k < n; k++) begin
      logic [7:0] ix;
      ix = byte_addr(a, k, bu) & 32'hFF;
      if (wr) begin
        logic [7:0] v;
        v = 8'(seed + k * 13);
        refm[ix] = v;
        w[31 - 8*(k % 4) -: 8] = v;
      end else begin
        w[31 - 8*(k % 4) -: 8] = refm[ix];
      end
      if (k % 4 == 3 || k == n - 1) begin
        if (wr) wq.push_back(w);
        else begin
          exp_rq.push_back(w);
          exp_lq.push_back(k == n - 1);
        end
        w = '0;
      end
    end
    seed += 29;
    @(negedge clk);
    cur_ps    = ps;
    req_valid = 1'b1;
    req_addr  = a;
    req_write = wr;
    req_port  = ps;
    req_burst = bu;
    req_bytes = 6'(n);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
    do begin @(negedge clk); #1; end while (!xfer_done);
    @(negedge clk);
    #1;
    chk(req_ready && !bus_ad_oe && !bus_ale, "R1 idle after request", 32'(req_ready), 32'h1);
    chk(exp_aq.size() == 0 && exp_bq.size() == 0 && exp_rq.size() == 0 && wq.size() == 0,
        "R4 beat and word counts", 32'(exp_bq.size() + exp_rq.size() + wq.size()), 32'h0);
    if (wr) begin
      mism = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== refm[i]) mism++;
      chk(mism == 0, "R4 R5 memory after write", 32'(mism), 32'h0);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) refm[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'h1);
    chk(!bus_ale && !bus_ad_oe, "R1 reset bus idle", {30'h0, bus_ale, bus_ad_oe}, 32'h0);
    chk(!bus_wstb && !bus_rstb, "R11 reset strobes", {30'h0, bus_wstb, bus_rstb}, 32'h0);
    chk(!rd_valid && !wd_ready && !xfer_done, "R10 reset streams", {29'h0, rd_valid, wd_ready, xfer_done}, 32'h0);

    run(32'h1234_5640, 1, 2'd2, 0, 8);   // R7 two address phases, 32-bit
    run(32'h1234_5648, 0, 2'd2, 1, 32);  // R6 full wrap burst read
    run(32'h8000_001E, 1, 2'd0, 1, 6);   // R6 byte burst wraps to offset 0
    run(32'h8000_001E, 0, 2'd0, 0, 6);   // R7 linear crosses block
    run(32'h0000_009C, 1, 2'd1, 1, 12);  // R4 halfword burst write with wrap
    run(32'h0000_009C, 0, 2'd1, 1, 12);  // R4 halfword burst read back
    run(32'h0000_0080, 0, 2'd1, 0, 4);   // R7 halfword single-phase
    run(32'h0000_00A0, 0, 2'd3, 0, 4);   // R4 code 3 as 32-bit
    run(32'h0000_0005, 0, 2'd0, 1, 32);  // R6 byte burst, 32 beats
    run(32'h0000_0003, 1, 2'd0, 0, 3);   // R8 partial word write
    run(32'h0000_0003, 0, 2'd0, 0, 3);   // R5 zero-filled tail lane

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule